// File: doc/BRIEF.md
# Paged Memory Bank Mapper

The block sits between a CPU with a 16-bit memory address space and a 1M physical space made of a 512K ROM and a 512K RAM, both divided into 16K pages. The CPU address space is cut into four 16K windows. Each window has a page register, and software loads that register with an I/O write. On each memory access the top two CPU address bits choose a window. The register of that window supplies the upper physical address bits and selects either the ROM or the RAM.

The CPU always places a full 16-bit address on I/O cycles, so the decoder looks only at the low address byte. The CPU may also move its address and data lines on the same clock edge on which it releases the write strobe. For this reason the block does not write a register while the strobe is active. It captures the port and the data on the first clock of the strobe and commits them once. The block ignores everything else until the strobe has gone inactive. A write to one window therefore cannot land in another window. Software reads the registers back through the same ports.

Top module: `bank_mapper`

## Requirements
- R1: After reset all four page registers hold 0x00, which is ROM page 0. With mem_req high, every CPU address maps to phys_addr = {6'b0, cpu_addr[13:0]} and rom_sel is high.
- R2: Port decode compares only cpu_addr[7:0] with 0x78..0x7B, and cpu_addr[15:8] has no effect. cpu_addr[1:0] picks the window: 0x78 is window 0 and 0x7B is window 3.
- R3: During a memory access, window w = cpu_addr[15:14] and phys_addr[19:0] = {page_w[5:0], cpu_addr[13:0]}. Bit 19 of phys_addr is the RAM flag.
- R4: rom_sel = mem_req and page bit 5 clear. ram_sel = mem_req and page bit 5 set. Both are low when mem_req is low.
- R5: A page register loads cpu_din[5:0] on the first rising clock edge at which io_req and wr_stb are both high and the port matches. Later edges of the same strobe change nothing, even when the address or data moves during the strobe. cpu_din[7:6] are discarded.
- R6: An edge at which the strobe is inactive changes no register, even when address and data change together with the release of the strobe. A write to window 1 never alters window 3.
- R7: An I/O write to a port outside 0x78..0x7B, such as 0x77 or 0x7C, changes no register.
- R8: When io_req and rd_stb are high and the port matches, io_dout = {2'b00, page_w} and io_dout_en is high. Otherwise io_dout is 0 and io_dout_en is low.
- R9: A write strobe during a memory request (mem_req high, io_req low) changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the CPU strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_din | input | 8 | CPU write data |
| mem_req | input | 1 | Memory request, active high |
| io_req | input | 1 | I/O request, active high |
| wr_stb | input | 1 | Write strobe, active high |
| rd_stb | input | 1 | Read strobe, active high |
| phys_addr | output | 20 | Physical address: RAM flag, page, offset |
| rom_sel | output | 1 | ROM chip select, active high |
| ram_sel | output | 1 | RAM chip select, active high |
| io_dout | output | 8 | Read-back data of the addressed page register |
| io_dout_en | output | 1 | High while io_dout carries read-back data |

## Verification
The bench builds the block with its default parameters: a 16-bit CPU address, four windows, 6-bit page registers and a port base of 0x78. With these values the highest page 0x3F reaches the last physical address 0xFFFFF. The bench drives ports 0x77 and 0x7C, on either side of the decoded range. It also drives upper address bytes of 0x00, 0x12, 0xAB and 0xFF. A strobe is held across several edges while address and data jump to window 3, and a strobe is released on the same edge where the address moves to window 3. Both cases show that window 3 keeps its value.

// File: rtl/bank_mapper.sv
module bank_mapper #(
  parameter int CPU_AW = 16,
  parameter int WIN_BITS = 2,
  parameter int PAGE_W = 6,
  parameter logic [7:0] PORT_BASE = 8'h78
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [CPU_AW-1:0]                  cpu_addr,
  input  logic [7:0]                         cpu_din,
  input  logic                               mem_req,
  input  logic                               io_req,
  input  logic                               wr_stb,
  input  logic                               rd_stb,
  output logic [PAGE_W+CPU_AW-WIN_BITS-1:0]  phys_addr,
  output logic                               rom_sel,
  output logic                               ram_sel,
  output logic [7:0]                         io_dout,
  output logic                               io_dout_en
);
  localparam int OFF_W = CPU_AW - WIN_BITS;
  localparam int NWIN  = 1 << WIN_BITS;

  logic [PAGE_W-1:0]      page_q [NWIN];
  logic [NWIN*PAGE_W-1:0] page_flat;
  logic                   armed_q;
  logic                   port_hit, commit;
  logic [WIN_BITS-1:0]    wr_idx, map_idx;
  logic [PAGE_W-1:0]      map_page, rd_page;
  logic                   unused_din_hi;

  assign port_hit = io_req && (cpu_addr[7:WIN_BITS] == PORT_BASE[7:WIN_BITS]);
  assign wr_idx   = cpu_addr[WIN_BITS-1:0];
  assign commit   = port_hit && wr_stb && armed_q;
  assign unused_din_hi = &{1'b0, cpu_din[7:PAGE_W]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed_q <= 1'b1;
    else        armed_q <= !(io_req && wr_stb);

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                            page_q[w] <= '0;
      else if (commit && wr_idx == WIN_BITS'(w)) page_q[w] <= cpu_din[PAGE_W-1:0];
    assign page_flat[w*PAGE_W +: PAGE_W] = page_q[w];
  end

  assign map_idx   = cpu_addr[CPU_AW-1 -: WIN_BITS];
  assign map_page  = page_q[map_idx];
  assign phys_addr = {map_page, cpu_addr[OFF_W-1:0]};
  assign rom_sel   = mem_req && !map_page[PAGE_W-1];
  assign ram_sel   = mem_req &&  map_page[PAGE_W-1];

  assign rd_page    = page_q[wr_idx];
  assign io_dout_en = port_hit && rd_stb;
  assign io_dout    = io_dout_en ? {{(8-PAGE_W){1'b0}}, rd_page} : 8'h00;
endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk #(
  parameter int CPU_AW = 16,
  parameter int PW = 20,
  parameter int FW = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CPU_AW-1:0] cpu_addr,
  input logic              mem_req,
  input logic              io_req,
  input logic              wr_stb,
  input logic [PW-1:0]     phys_addr,
  input logic              rom_sel,
  input logic              ram_sel,
  input logic [7:0]        io_dout,
  input logic              io_dout_en,
  input logic [FW-1:0]     page_flat
);
  logic seen_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;

  // R4
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_sel, ram_sel}) && (mem_req || !(rom_sel || ram_sel)));

  // R3
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> phys_addr[CPU_AW-3:0] == cpu_addr[CPU_AW-3:0]);

  // R3
  ramflag_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ram_sel == phys_addr[PW-1]);

  // R5
  held_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && io_req && wr_stb && $past(io_req && wr_stb)) |=> $stable(page_flat));

  // R6
  idle_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_req && wr_stb) |=> $stable(page_flat));

  // R8
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_dout_en |-> io_dout == 8'h00);

  // R8
  rd_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_dout_en |-> io_dout[7:6] == 2'b00);
endmodule

bind bank_mapper bank_mapper_chk #(
  .CPU_AW(CPU_AW), .PW(PAGE_W + CPU_AW - WIN_BITS), .FW((1 << WIN_BITS) * PAGE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mem_req(mem_req),
  .io_req(io_req), .wr_stb(wr_stb), .phys_addr(phys_addr),
  .rom_sel(rom_sel), .ram_sel(ram_sel), .io_dout(io_dout),
  .io_dout_en(io_dout_en), .page_flat(page_flat)
);

// File: tb/sim_bank_mapper.sv
module sim_bank_mapper;
  logic        clk = 0, rst_n = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0]  cpu_din = 0;
  logic        mem_req = 0, io_req = 0, wr_stb = 0, rd_stb = 0;
  logic [19:0] phys_addr;
  logic        rom_sel, ram_sel, io_dout_en;
  logic [7:0]  io_dout;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bank_mapper u0 (.*);

  // {port, data, probe addr, expected phys, expected ram}
  localparam logic [60:0] VEC [5] = '{
    {16'hFF78, 8'h21, 16'h1234, 20'h85234, 1'b1},
    {16'h0079, 8'h05, 16'h4ABC, 20'h14ABC, 1'b0},
    {16'h127A, 8'h3F, 16'hBFFF, 20'hFFFFF, 1'b1},
    {16'hAB7B, 8'hE0, 16'hC000, 20'h80000, 1'b1},
    {16'hFF78, 8'h1F, 16'h3FFF, 20'h7FFFF, 1'b0}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic io_write(logic [15:0] a, logic [7:0] d, logic [15:0] a_rel, logic [7:0] d_rel);
    @(negedge clk); cpu_addr = a; cpu_din = d; io_req = 1; wr_stb = 1;
    @(negedge clk); cpu_addr = a_rel; cpu_din = d_rel; io_req = 0; wr_stb = 0;
    @(negedge clk);
  endtask

  task automatic io_read(logic [15:0] a, output logic [7:0] v, output logic en);
    @(negedge clk); cpu_addr = a; io_req = 1; rd_stb = 1;
    #2; v = io_dout; en = io_dout_en;
    io_req = 0; rd_stb = 0;
  endtask

  task automatic probe(logic [15:0] a, output logic [19:0] p, output logic ro, output logic ra);
    @(negedge clk); cpu_addr = a; mem_req = 1;
    #2; p = phys_addr; ro = rom_sel; ra = ram_sel;
    mem_req = 0;
  endtask

  task automatic expect_regs(string tag, logic [7:0] e0, logic [7:0] e1, logic [7:0] e2, logic [7:0] e3);
    logic [7:0] v; logic en;
    io_read(16'h0078, v, en); chk(tag, {en, v}, {1'b1, e0});
    io_read(16'h5579, v, en); chk(tag, {en, v}, {1'b1, e1});
    io_read(16'hFF7A, v, en); chk(tag, {en, v}, {1'b1, e2});
    io_read(16'h037B, v, en); chk(tag, {en, v}, {1'b1, e3});
  endtask

  initial begin
    logic [19:0] p; logic ro, ra, en; logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset mapping and read-back
    probe(16'h0000, p, ro, ra); chk("R1 win0", {p, ro, ra}, {20'h00000, 2'b10});
    probe(16'h7FFF, p, ro, ra); chk("R1 win1", {p, ro, ra}, {20'h03FFF, 2'b10});
    probe(16'hFFFF, p, ro, ra); chk("R1 win3", {p, ro, ra}, {20'h03FFF, 2'b10});
    expect_regs("R1 R8 reset readback", 8'h00, 8'h00, 8'h00, 8'h00);

    // R2 R3 R4 vector table
    foreach (VEC[i]) begin
      io_write(VEC[i][60:45], VEC[i][44:37], 16'h0000, 8'h00);
      probe(VEC[i][36:21], p, ro, ra);
      chk("R2 R3 R4 vector", {p, ro, ra}, {VEC[i][20:1], ~VEC[i][0], VEC[i][0]});
    end
    expect_regs("R8 after vectors", 8'h1F, 8'h05, 8'h3F, 8'h20);

    // R4 no select without mem_req
    @(negedge clk); cpu_addr = 16'hC000; mem_req = 0; #2;
    chk("R4 idle selects", {rom_sel, ram_sel}, 2'b00);

    // R7 out-of-range ports
    io_write(16'hFF77, 8'h33, 16'h0000, 8'h00);
    io_write(16'hFF7C, 8'h33, 16'h0000, 8'h00);
    expect_regs("R7 neighbours ignored", 8'h1F, 8'h05, 8'h3F, 8'h20);

    // R9 memory write strobe
    @(negedge clk); cpu_addr = 16'h0079; cpu_din = 8'h33; mem_req = 1; wr_stb = 1;
    @(negedge clk); mem_req = 0; wr_stb = 0;
    expect_regs("R9 memory write ignored", 8'h1F, 8'h05, 8'h3F, 8'h20);

    // R5 held strobe, address and data move to window 3 mid-strobe
    @(negedge clk); cpu_addr = 16'hFF79; cpu_din = 8'h0A; io_req = 1; wr_stb = 1;
    @(negedge clk); cpu_addr = 16'hFF7B; cpu_din = 8'h2C;
    @(negedge clk); @(negedge clk); io_req = 0; wr_stb = 0;
    expect_regs("R5 single commit", 8'h1F, 8'h0A, 8'h3F, 8'h20);

    // R6 release edge with address moving to window 3
    io_write(16'hFF79, 8'h11, 16'hFF7B, 8'h2D);
    expect_regs("R6 release edge", 8'h1F, 8'h11, 8'h3F, 8'h20);
    probe(16'hC123, p, ro, ra); chk("R6 window3 map", {p, ro, ra}, {20'h80123, 2'b01});

    // R8 idle and miss read
    @(negedge clk); cpu_addr = 16'h0079; io_req = 1; rd_stb = 0; #2;
    chk("R8 no rd", {io_dout_en, io_dout}, 9'h000);
    io_req = 0;
    io_read(16'h007C, v, en); chk("R8 miss port", {en, v}, 9'h000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule